// File: doc/BRIEF.md
# Serial wire debug host engine

This block runs one serial wire debug transfer from the host side. A single `start` pulse latches a 4-bit request, 32-bit write data and the transfer settings. The engine then produces the serial clock, drives or releases the bidirectional data line through separate output, output-enable and input pins, and finishes with a one-cycle `done` pulse. At that point the acknowledge, a status code and any read data are presented.

The engine sends the request header with its parity bit and inserts turnaround periods whose length is programmable. It collects the acknowledge and then takes the path that the acknowledge selects. On OK it moves a 32-bit word with parity in either direction and may append idle clocks. On WAIT or FAULT it can optionally drain the data phase. On any other acknowledge it flushes the line. The bit rate comes from a half-period divider. Line resets, access sequencing and retries are left to the logic that drives `start`.

Top module: `swd_xfer_engine`

## Requirements
- R1: While no transfer runs, `swclk` is 1, `swdio_oe` is 1, `swdio_o` is 1 and `busy` is 0.
- R2: `start` begins a transfer only while `busy` is 0. A `start` or a request change during a transfer leaves its line sequence and results unchanged.
- R3: Every bit period has a low phase of H = `half_period`+1 system cycles followed by a high phase of H cycles. The driven value is set at the start of the low phase, and `swdio_i` is sampled in the last cycle of the low phase.
- R4: The first 8 bit periods drive, in this order: 1, `req[0]`, `req[1]`, `req[2]`, `req[3]`, the XOR of `req[3:0]`, 0, 1. `req[1]`=1 marks a read.
- R5: After the header the line is released for `turn_sel`+1 bit periods (1 to 4).
- R6: The acknowledge is read over 3 released periods, LSB first. 3'b001 is OK, 3'b010 is WAIT and 3'b100 is FAULT. On an OK read, 32 data bits LSB first and one parity bit are read with the line released, followed by a turnaround. `rdata` is the word. `status` is 4'b1000 when the XOR of all 33 bits is 1, and 4'b0001 otherwise.
- R7: On an OK write, a turnaround comes first. Then `wdata` is driven over 32 periods LSB first, followed by the XOR of `wdata`.
- R8: After an OK transfer the line is driven low for `idle_len` periods. A zero count adds none.
- R9: On WAIT or FAULT with `drain_en`=1, a read releases the line for 33 periods plus a turnaround, and a write drives 0 for 33 periods. `status` equals `ack`.
- R10: On WAIT or FAULT with `drain_en`=0, the transfer ends right after the acknowledge.
- R11: On any other acknowledge value, the line is released for `turn_sel`+34 periods. `status` is the acknowledge zero-extended to 4 bits.
- R12: `done` is high for exactly one cycle, in the cycle after the last high phase. `busy` falls in that same cycle, and `ack`, `status` and `rdata` are valid then. `rdata` is 0 unless an OK read took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| req | input | 4 | Port select, read flag, address bits 3:2 |
| wdata | input | 32 | Write word |
| half_period | input | DIV_W | System cycles per clock half, minus one |
| turn_sel | input | 2 | Turnaround periods minus one |
| idle_len | input | IDLE_W | Idle periods appended after an OK transfer |
| drain_en | input | 1 | Drain the data phase on WAIT/FAULT |
| swdio_i | input | 1 | Data line input |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | End-of-transfer pulse |
| ack | output | 3 | Received acknowledge |
| status | output | 4 | Result code |
| rdata | output | 32 | Read word |

## Verification
The bench builds the engine with DIV_W=3 and IDLE_W=5. This keeps bit periods short while still allowing half-periods of 1 to 3 cycles, so sampling in the last low cycle is exercised with more than one cycle per phase. It also allows idle tails of several clocks, which fit in a short run. Every turnaround length, every acknowledge path in both directions (drained and undrained), a corrupted read parity and two invalid acknowledges are covered against a per-cycle expectation of clock, enable and line value.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ACK_W    = 3;
  localparam int unsigned STAT_W   = 4;
  localparam logic [2:0]  ACK_OK    = 3'b001;
  localparam logic [2:0]  ACK_WAIT  = 3'b010;
  localparam logic [2:0]  ACK_FAULT = 3'b100;
  localparam logic [3:0]  ST_OK     = 4'b0001;
  localparam logic [3:0]  ST_PARITY = 4'b1000;

  typedef enum logic [3:0] {
    PH_IDLE, PH_HDR, PH_TRN1, PH_ACK, PH_RDATA,
    PH_TRN2, PH_WDATA, PH_TAIL, PH_DRAIN, PH_FLUSH
  } phase_e;
endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cnt,
  output logic             clk_low,
  output logic             sample_stb,
  output logic             bit_end_stb
);
  logic [DIV_W-1:0] hcnt_q, hcnt_d;
  logic             hi_q, hi_d;
  logic             wrap;

  assign wrap = (hcnt_q == half_cnt);

  always_comb begin
    hcnt_d = hcnt_q;
    hi_d   = hi_q;
    if (!run) begin
      hcnt_d = '0;
      hi_d   = 1'b0;
    end else if (wrap) begin
      hcnt_d = '0;
      hi_d   = ~hi_q;
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      hi_q   <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      hi_q   <= hi_d;
    end
  end

  assign clk_low     = run & ~hi_q;
  assign sample_stb  = run & ~hi_q & wrap;
  assign bit_end_stb = run & hi_q & wrap;
endmodule

// File: rtl/swd_line_drv.sv
module swd_line_drv
  import swd_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  phase_e            phase,
  input  logic [CNT_W-1:0]  idx,
  input  logic [3:0]        req,
  input  logic [WORD_W-1:0] wdata,
  output logic              oe,
  output logic              dout
);
  logic [7:0] hdr;
  logic       wbit;

  assign hdr  = {1'b1, 1'b0, ^req, req, 1'b1};
  assign wbit = (idx < CNT_W'(WORD_W)) ? wdata[idx[4:0]] : ^wdata;

  always_comb begin
    oe   = 1'b1;
    dout = 1'b1;
    case (phase)
      PH_HDR:   dout = hdr[idx[2:0]];
      PH_WDATA: dout = wbit;
      PH_TAIL:  dout = 1'b0;
      PH_DRAIN: begin
        oe   = ~req[1];
        dout = 1'b0;
      end
      PH_TRN1, PH_TRN2, PH_ACK, PH_RDATA, PH_FLUSH: oe = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned IDLE_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        req_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic [1:0]        turn_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              drain_i,
  input  logic              sample_stb,
  input  logic              bit_end_stb,
  input  logic              din,
  output logic              busy,
  output logic              done,
  output phase_e            phase,
  output logic [CNT_W-1:0]  idx,
  output logic [3:0]        req_q,
  output logic [WORD_W-1:0] wdata_q,
  output logic [DIV_W-1:0]  half_q,
  output logic [ACK_W-1:0]  ack_q,
  output logic [STAT_W-1:0] status_q,
  output logic [WORD_W-1:0] rdata_q
);
  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    idx_q, idx_d, seg_last;
  logic [3:0]          req_d;
  logic [WORD_W-1:0]   wdata_d, rdata_d;
  logic [DIV_W-1:0]    half_d;
  logic [1:0]          turn_q, turn_d;
  logic [IDLE_W-1:0]   idle_q, idle_d;
  logic                drain_q, drain_d, done_q, done_d, fin;
  logic [ACK_W-1:0]    ack_d;
  logic [STAT_W-1:0]   status_d;
  logic [WORD_W:0]     shift_q, shift_d;
  logic                rnw, tail_go;

  assign rnw     = req_q[1];
  assign tail_go = (idle_q != '0);

  always_comb begin
    case (phase_q)
      PH_HDR:                     seg_last = CNT_W'(7);
      PH_TRN1, PH_TRN2:           seg_last = CNT_W'(turn_q);
      PH_ACK:                     seg_last = CNT_W'(ACK_W - 1);
      PH_RDATA, PH_WDATA, PH_DRAIN: seg_last = CNT_W'(WORD_W);
      PH_TAIL:                    seg_last = CNT_W'(idle_q) - 1'b1;
      PH_FLUSH:                   seg_last = CNT_W'(turn_q) + CNT_W'(WORD_W + 1);
      default:                    seg_last = '0;
    endcase
  end

  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    req_d    = req_q;
    wdata_d  = wdata_q;
    half_d   = half_q;
    turn_d   = turn_q;
    idle_d   = idle_q;
    drain_d  = drain_q;
    ack_d    = ack_q;
    status_d = status_q;
    rdata_d  = rdata_q;
    shift_d  = shift_q;
    done_d   = 1'b0;
    fin      = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d  = PH_HDR;
        idx_d    = '0;
        req_d    = req_i;
        wdata_d  = wdata_i;
        half_d   = half_i;
        turn_d   = turn_i;
        idle_d   = idle_i;
        drain_d  = drain_i;
        ack_d    = '0;
        status_d = '0;
        rdata_d  = '0;
      end
    end else begin
      if (sample_stb && phase_q == PH_ACK)   ack_d   = {din, ack_q[ACK_W-1:1]};
      if (sample_stb && phase_q == PH_RDATA) shift_d = {din, shift_q[WORD_W:1]};
      if (bit_end_stb) begin
        if (idx_q != seg_last) begin
          idx_d = idx_q + 1'b1;
        end else begin
          idx_d = '0;
          case (phase_q)
            PH_HDR:  phase_d = PH_TRN1;
            PH_TRN1: phase_d = PH_ACK;
            PH_ACK: begin
              status_d = {1'b0, ack_q};
              if (ack_q == ACK_OK) begin
                phase_d = rnw ? PH_RDATA : PH_TRN2;
              end else if (ack_q == ACK_WAIT || ack_q == ACK_FAULT) begin
                if (drain_q) phase_d = PH_DRAIN;
                else         fin     = 1'b1;
              end else begin
                phase_d = PH_FLUSH;
              end
            end
            PH_RDATA: begin
              rdata_d = shift_q[WORD_W-1:0];
              if (^shift_q) status_d = ST_PARITY;
              phase_d = PH_TRN2;
            end
            PH_TRN2: begin
              if (ack_q != ACK_OK || rnw) begin
                if (ack_q == ACK_OK && tail_go) phase_d = PH_TAIL;
                else                            fin     = 1'b1;
              end else begin
                phase_d = PH_WDATA;
              end
            end
            PH_WDATA: begin
              if (tail_go) phase_d = PH_TAIL;
              else         fin     = 1'b1;
            end
            PH_DRAIN: begin
              if (rnw) phase_d = PH_TRN2;
              else     fin     = 1'b1;
            end
            default: fin = 1'b1;
          endcase
          if (fin) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      req_q    <= '0;
      wdata_q  <= '0;
      half_q   <= '0;
      turn_q   <= '0;
      idle_q   <= '0;
      drain_q  <= 1'b0;
      ack_q    <= '0;
      status_q <= '0;
      rdata_q  <= '0;
      shift_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      req_q    <= req_d;
      wdata_q  <= wdata_d;
      half_q   <= half_d;
      turn_q   <= turn_d;
      idle_q   <= idle_d;
      drain_q  <= drain_d;
      ack_q    <= ack_d;
      status_q <= status_d;
      rdata_q  <= rdata_d;
      shift_q  <= shift_d;
      done_q   <= done_d;
    end
  end

  assign busy  = (phase_q != PH_IDLE);
  assign done  = done_q;
  assign phase = phase_q;
  assign idx   = idx_q;
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
  import swd_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        req,
  input  logic [WORD_W-1:0] wdata,
  input  logic [DIV_W-1:0]  half_period,
  input  logic [1:0]        turn_sel,
  input  logic [IDLE_W-1:0] idle_len,
  input  logic              drain_en,
  input  logic              swdio_i,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  output logic              busy,
  output logic              done,
  output logic [ACK_W-1:0]  ack,
  output logic [STAT_W-1:0] status,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

  phase_e            phase;
  logic [CNT_W-1:0]  idx;
  logic [3:0]        req_q;
  logic [WORD_W-1:0] wdata_q;
  logic [DIV_W-1:0]  half_q;
  logic              clk_low, sample_stb, bit_end_stb;

  swd_bit_timer #(.DIV_W(DIV_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_cnt(half_q),
    .clk_low(clk_low), .sample_stb(sample_stb), .bit_end_stb(bit_end_stb)
  );

  swd_seq #(.DIV_W(DIV_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_i(req), .wdata_i(wdata),
    .half_i(half_period), .turn_i(turn_sel), .idle_i(idle_len),
    .drain_i(drain_en), .sample_stb(sample_stb), .bit_end_stb(bit_end_stb),
    .din(swdio_i), .busy(busy), .done(done), .phase(phase), .idx(idx),
    .req_q(req_q), .wdata_q(wdata_q), .half_q(half_q), .ack_q(ack),
    .status_q(status), .rdata_q(rdata)
  );

  swd_line_drv #(.CNT_W(CNT_W)) i_drv (
    .phase(phase), .idx(idx), .req(req_q), .wdata(wdata_q),
    .oe(swdio_oe), .dout(swdio_o)
  );

  assign swclk = ~clk_low;
endmodule

// File: rtl/swd_xfer_chk.sv
module swd_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       swclk,
  input logic       swdio_o,
  input logic       swdio_oe,
  input logic [2:0] ack,
  input logic [3:0] status
);
  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swclk && swdio_oe && swdio_o))
    else $error("idle line not parked high");

  p_begin_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start))
    else $error("transfer began without start");

  p_first_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!swclk && swdio_oe && swdio_o))
    else $error("header start bit wrong");

  p_parity_ok_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 4'b1000) |-> (ack == 3'b001))
    else $error("parity error without OK ack");

  p_bad_ack_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ack != 3'b001 && ack != 3'b010 && ack != 3'b100) |-> (status == {1'b0, ack}))
    else $error("invalid ack status wrong");

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_done_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)))
    else $error("done not at end of transfer");
endmodule

bind swd_xfer_engine swd_xfer_chk i_swd_xfer_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
  .ack(ack), .status(status)
);

// File: tb/test_swd_xfer_engine.sv
`timescale 1ns/1ps
module test_swd_xfer_engine;
  localparam int DIV_W  = 3;
  localparam int IDLE_W = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [3:0]        req;
  logic [31:0]       wdata;
  logic [DIV_W-1:0]  half_period;
  logic [1:0]        turn_sel;
  logic [IDLE_W-1:0] idle_len;
  logic              drain_en;
  logic              swdio_i;
  logic              swclk, swdio_o, swdio_oe, busy, done;
  logic [2:0]        ack;
  logic [3:0]        status;
  logic [31:0]       rdata;

  int compared   = 0;
  int mismatched = 0;

  bit    q_oe[$];
  bit    q_o[$];
  bit    q_in[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  swd_xfer_engine #(.DIV_W(DIV_W), .IDLE_W(IDLE_W)) i_swd_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .wdata(wdata),
    .half_period(half_period), .turn_sel(turn_sel), .idle_len(idle_len),
    .drain_en(drain_en), .swdio_i(swdio_i), .swclk(swclk), .swdio_o(swdio_o),
    .swdio_oe(swdio_oe), .busy(busy), .done(done), .ack(ack),
    .status(status), .rdata(rdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input bit oe, input bit o, input bit din, input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      q_oe.push_back(oe); q_o.push_back(o); q_in.push_back(din); q_tag.push_back(tag);
    end
  endtask

  task automatic idle_check(input string tag);
    check(tag, "swclk", swclk, 1);
    check(tag, "swdio_oe", swdio_oe, 1);
    check(tag, "swdio_o", swdio_o, 1);
    check(tag, "busy", busy, 0);
  endtask

  // Expectation built from R3..R11; completion checked per R12, poke per R2.
  task automatic run_xfer(input logic [3:0] rq, input logic [31:0] wd, input int half,
                          input int turn, input int idl, input bit drn,
                          input logic [2:0] ackv, input logic [31:0] rd,
                          input bit corrupt, input bit poke);
    logic [3:0]  exp_st;
    logic [31:0] exp_rd;
    bit          rnw;
    int          cyc;
    int          hlen;
    rnw    = rq[1];
    exp_rd = 32'h0;
    hlen   = half + 1;
    // R4 header
    push(1, 1, 1, "R4", 1);
    for (int i = 0; i < 4; i++) push(1, rq[i], 1, "R4", 1);
    push(1, ^rq, 1, "R4", 1);
    push(1, 0, 1, "R4", 1);
    push(1, 1, 1, "R4", 1);
    push(0, 1, 1, "R5", turn + 1);
    for (int i = 0; i < 3; i++) push(0, 1, ackv[i], "R6", 1);
    if (ackv == 3'b001) begin
      exp_st = 4'b0001;
      if (rnw) begin
        for (int i = 0; i < 32; i++) push(0, 1, rd[i], "R6", 1);
        push(0, 1, (^rd) ^ corrupt, "R6", 1);
        if (corrupt) exp_st = 4'b1000;
        exp_rd = rd;
        push(0, 1, 1, "R6", turn + 1);
      end else begin
        push(0, 1, 1, "R7", turn + 1);
        for (int i = 0; i < 32; i++) push(1, wd[i], 1, "R7", 1);
        push(1, ^wd, 1, "R7", 1);
      end
      push(1, 0, 1, "R8", idl);
    end else if (ackv == 3'b010 || ackv == 3'b100) begin
      exp_st = {1'b0, ackv};
      if (drn) begin
        if (rnw) begin
          push(0, 1, 1, "R9", 33);
          push(0, 1, 1, "R9", turn + 1);
        end else begin
          push(1, 0, 1, "R9", 33);
        end
      end
      // R10: with drn=0 nothing follows the acknowledge
    end else begin
      exp_st = {1'b0, ackv};
      push(0, 1, 1, "R11", turn + 34);
    end

    @(negedge clk);
    start = 1'b1; req = rq; wdata = wd; half_period = DIV_W'(half);
    turn_sel = 2'(turn); idle_len = IDLE_W'(idl); drain_en = drn;
    cyc = 0;
    while (q_oe.size() > 0) begin
      bit    b_oe, b_o, b_in;
      string b_tag;
      b_oe = q_oe.pop_front(); b_o = q_o.pop_front();
      b_in = q_in.pop_front(); b_tag = q_tag.pop_front();
      for (int ph = 0; ph < 2; ph++) begin
        for (int c = 0; c < hlen; c++) begin
          @(negedge clk);
          start = 1'b0; req = rq;
          if (poke && (cyc == 10 || cyc == 11)) begin
            start = 1'b1; req = ~rq;  // R2: ignored while busy
          end
          swdio_i = b_in;
          check("R3", "swclk", swclk, ph);
          check("R2", "busy", busy, 1);
          check("R12", "done", done, 0);
          check(b_tag, "swdio_oe", swdio_oe, b_oe);
          if (b_oe) check(b_tag, "swdio_o", swdio_o, b_o);
          cyc++;
        end
      end
    end
    @(negedge clk);
    start = 1'b0; swdio_i = 1'b1;
    check("R12", "done", done, 1);
    idle_check("R1");
    check("R12", "ack", ack, ackv);
    check("R12", "status", status, exp_st);
    check("R12", "rdata", rdata, exp_rd);
    @(negedge clk);
    check("R12", "done_low", done, 0);
    idle_check("R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req = '0; wdata = '0; half_period = '0;
    turn_sel = '0; idle_len = '0; drain_en = 1'b0; swdio_i = 1'b1;
    repeat (3) @(negedge clk);
    idle_check("R1");
    check("R12", "done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_check("R1");
    // R6 OK reads: minimal timing, then slow clock, long turnaround, idle tail (R8)
    run_xfer(4'b0010, 32'h0, 0, 0, 0, 0, 3'b001, 32'h1234_5678, 0, 0);
    run_xfer(4'b1111, 32'h0, 2, 3, 3, 0, 3'b001, 32'hA5A5_0F0F, 0, 0);
    // R6 parity error
    run_xfer(4'b0110, 32'h0, 1, 1, 2, 0, 3'b001, 32'h8000_0001, 1, 0);
    // R7 writes, with a start poke mid-transfer (R2) and an idle tail (R8)
    run_xfer(4'b0100, 32'hDEAD_BEEF, 1, 1, 0, 0, 3'b001, 32'h0, 0, 1);
    run_xfer(4'b1001, 32'h0000_FFFF, 0, 2, 5, 0, 3'b001, 32'h0, 0, 0);
    // R9 drained WAIT read, drained FAULT write
    run_xfer(4'b0011, 32'h0, 0, 1, 4, 1, 3'b010, 32'h0, 0, 0);
    run_xfer(4'b1000, 32'h1357_9BDF, 1, 0, 4, 1, 3'b100, 32'h0, 0, 0);
    // R10 undrained WAIT write and FAULT read
    run_xfer(4'b0000, 32'h1, 0, 0, 2, 0, 3'b010, 32'h0, 0, 0);
    run_xfer(4'b1110, 32'h0, 2, 3, 2, 0, 3'b100, 32'h0, 0, 0);
    // R11 invalid acknowledges
    run_xfer(4'b0010, 32'h0, 0, 2, 1, 1, 3'b111, 32'h0, 0, 0);
    run_xfer(4'b0101, 32'h0, 1, 0, 1, 0, 3'b000, 32'h0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule